// File: doc/BRIEF.md
# I/Q Sample Bit-Window Packer and Unpacker

This block narrows a stream of 16-bit signed complex samples before they cross a transfer bus, and restores them on the far side. In narrow mode, a shift setting picks which contiguous 8-bit slice of each component to keep. A small expected signal keeps its low-order bits. A large signal keeps its high-order bits. A component whose value does not fit in the chosen slice is clamped to the nearest 8-bit limit instead of wrapping. The two reduced components share one 16-bit bus word. In wide mode, the full 16-bit components pass unchanged as two consecutive bus words.

The unpacker reverses the process. In narrow mode it places each received byte back at the bit position it came from. It sign-extends the byte and fills the vacated low bits with zero, so the restored value keeps its full-scale magnitude. In wide mode it joins two bus words back into one I/Q pair.

Converter data reaches the packer left-justified. A 14-bit conversion sits in the top 14 bits, with the two low bits zero.

Every stream uses a valid/ready handshake. The mode and shift setting are taken only when a pair is accepted, so no pair ever mixes two settings.

Top module: `iqBitWindowPacker`

## Requirements
- R1: In narrow mode, with shift k from 0 to 8 and a component value that fits, the kept byte is bits [15-k:8-k] of the component. k=0 keeps [15:8], k=1 keeps [14:7], and k=8 keeps [7:0].
- R2: A component whose arithmetic right shift by 8-k lies outside -128..127 is sent as 0x7F if positive or 0x80 if negative, instead of wrapping.
- R3: A shift setting above 8 (9 to 15) behaves exactly like k=8, on both the packer and the unpacker.
- R4: In narrow mode (cfgNarrow=1), each accepted pair produces one bus word, with the I byte in bits [15:8] and the Q byte in bits [7:0].
- R5: In wide mode (cfgNarrow=0), each accepted pair produces two bus words: first I, then Q, both unmodified. The packer does not accept a new pair until the Q word has been taken.
- R6: While busValid is high and busReady is low, busValid stays high and busData does not change. While the packer holds a word, inReady is low.
- R7: The mode and shift are sampled only when a pair is accepted. Changing them while that pair's words are still pending does not alter those words.
- R8: In narrow mode, one received word yields one output pair. Each component is the sign-extended byte shifted left by 8-k, with the low 8-k bits zero. I comes from bits [15:8] and Q from bits [7:0].
- R9: In wide mode, the unpacker takes two received words as I then Q, and emits them unchanged as one output pair.
- R10: While outValid is high and outReady is low, outValid, outI and outQ hold, and no further pair-completing word is accepted (rxReady low).
- R11: After reset, busValid and outValid are low, and inReady and rxReady are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgNarrow | input | 1 | 1: 8 bits per component, 0: full 16 bits |
| cfgShift | input | 4 | Expected-peak shift k (values above 8 act as 8) |
| inValid | input | 1 | Input pair valid |
| inReady | output | 1 | Packer can accept a pair |
| inI | input | 16 | Input in-phase component |
| inQ | input | 16 | Input quadrature component |
| busValid | output | 1 | Bus word valid |
| busReady | input | 1 | Bus consumer ready |
| busData | output | 16 | Packed bus word |
| rxValid | input | 1 | Received bus word valid |
| rxReady | output | 1 | Unpacker can accept a word |
| rxData | input | 16 | Received bus word |
| outValid | output | 1 | Restored pair valid |
| outReady | input | 1 | Downstream ready for restored pair |
| outI | output | 16 | Restored in-phase component |
| outQ | output | 16 | Restored quadrature component |

## Verification
The assertions assume a source that keeps its data stable while its valid is high and unaccepted. They also assume that the setting seen when a narrow word reaches the unpacker matches the one used to pack it. The bench drives every input only on falling edges. It holds valid and data until it sees ready, and it changes cfgNarrow or cfgShift only while the receive side is idle. Backpressure is applied by parking busReady or outReady low, never by dropping valid.

// File: rtl/iqbwPkg.sv
package iqbwPkg;
  // Single-cycle strobes issued by the control to the datapath
  typedef struct packed {
    logic loadPair;    // packer accepted an I/Q pair
    logic loadQWord;   // packer moves held Q word onto the bus
    logic holdRxI;     // unpacker stores the wide-mode I word
    logic emitNarrow;  // unpacker expands one narrow word into a pair
    logic emitWide;    // unpacker completes a wide pair
  } iqbwStrobe_t;
endpackage

// File: rtl/iqbwCtrl.sv
module iqbwCtrl
  import iqbwPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgNarrow,
  input  logic        inValid,
  output logic        inReady,
  output logic        busValid,
  input  logic        busReady,
  input  logic        rxValid,
  output logic        rxReady,
  output logic        outValid,
  input  logic        outReady,
  output iqbwStrobe_t st
);
  logic txPhase;   // 1: Q word of a wide pair is still pending
  logic rxPhase;   // 1: I word of a wide pair already held
  logic busValidR;
  logic outValidR;
  logic accIn;
  logic sendQ;
  logic accRx;
  logic rxSlotFree;

  assign busValid   = busValidR;
  assign outValid   = outValidR;
  assign inReady    = !txPhase && (!busValidR || busReady);
  assign accIn      = inValid && inReady;
  assign sendQ      = txPhase && busReady;
  assign rxSlotFree = !outValidR || outReady;
  assign rxReady    = (rxPhase || cfgNarrow) ? rxSlotFree : 1'b1;
  assign accRx      = rxValid && rxReady;

  always_comb begin
    st            = '0;
    st.loadPair   = accIn;
    st.loadQWord  = sendQ;
    st.holdRxI    = accRx && !rxPhase && !cfgNarrow;
    st.emitNarrow = accRx && !rxPhase && cfgNarrow;
    st.emitWide   = accRx && rxPhase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busValidR <= 1'b0;
      txPhase   <= 1'b0;
      outValidR <= 1'b0;
      rxPhase   <= 1'b0;
    end else begin
      if (accIn || sendQ)  busValidR <= 1'b1;
      else if (busReady)   busValidR <= 1'b0;

      if (accIn)           txPhase <= !cfgNarrow;
      else if (sendQ)      txPhase <= 1'b0;

      if (st.emitNarrow || st.emitWide) outValidR <= 1'b1;
      else if (outReady)                outValidR <= 1'b0;

      if (st.holdRxI)      rxPhase <= 1'b1;
      else if (st.emitWide) rxPhase <= 1'b0;
    end
  end

  // R5: a wide pair blocks the input until its Q word has gone
  a_r5_wide_blocks_input: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && !cfgNarrow |=> busValid && !inReady);

  // R6: an unaccepted bus word stays valid
  a_r6_bus_valid_hold: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busReady |=> busValid);

  // R10: an unaccepted restored pair stays valid
  a_r10_out_valid_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);
endmodule

// File: rtl/iqbwData.sv
module iqbwData
  import iqbwPkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int NARROW_W = 8,
  parameter int SHIFT_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  iqbwStrobe_t         st,
  input  logic                cfgNarrow,
  input  logic [SHIFT_W-1:0]  cfgShift,
  input  logic [SAMPLE_W-1:0] inI,
  input  logic [SAMPLE_W-1:0] inQ,
  input  logic [SAMPLE_W-1:0] rxData,
  output logic [SAMPLE_W-1:0] busData,
  output logic [SAMPLE_W-1:0] outI,
  output logic [SAMPLE_W-1:0] outQ
);
  localparam int MAX_SHIFT = SAMPLE_W - NARROW_W;
  localparam logic signed [SAMPLE_W-1:0] POS_LIM = SAMPLE_W'(2 ** (NARROW_W - 1) - 1);
  localparam logic signed [SAMPLE_W-1:0] NEG_LIM = ~POS_LIM;

  function automatic logic [SHIFT_W-1:0] clampShift(input logic [SHIFT_W-1:0] k);
    return (int'(k) > MAX_SHIFT) ? SHIFT_W'(MAX_SHIFT) : k;
  endfunction

  // Keep bits [SAMPLE_W-1-k : MAX_SHIFT-k], clamping values that overflow
  function automatic logic [NARROW_W-1:0] windowSat(input logic [SAMPLE_W-1:0] x,
                                                     input logic [SHIFT_W-1:0]  k);
    logic signed [SAMPLE_W-1:0] sh;
    sh = $signed(x) >>> (MAX_SHIFT - int'(clampShift(k)));
    if (sh > POS_LIM)      return NARROW_W'(POS_LIM);
    else if (sh < NEG_LIM) return NARROW_W'(NEG_LIM);
    else                   return sh[NARROW_W-1:0];
  endfunction

  // Return a narrow value to its original bit position
  function automatic logic [SAMPLE_W-1:0] expand(input logic [NARROW_W-1:0] v,
                                                 input logic [SHIFT_W-1:0]  k);
    logic [SAMPLE_W-1:0] e;
    e = {{(SAMPLE_W - NARROW_W){v[NARROW_W-1]}}, v};
    return e << (MAX_SHIFT - int'(clampShift(k)));
  endfunction

  logic [SAMPLE_W-1:0] qHold;
  logic [SAMPLE_W-1:0] rxHold;
  logic [SHIFT_W-1:0]  outShift;
  logic [SAMPLE_W-1:0] lowMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busData  <= '0;
      qHold    <= '0;
      rxHold   <= '0;
      outI     <= '0;
      outQ     <= '0;
      outShift <= '0;
    end else begin
      if (st.loadPair) begin
        busData <= cfgNarrow ? SAMPLE_W'({windowSat(inI, cfgShift), windowSat(inQ, cfgShift)})
                             : inI;
        qHold   <= inQ;
      end else if (st.loadQWord) begin
        busData <= qHold;
      end

      if (st.holdRxI) rxHold <= rxData;

      if (st.emitNarrow) begin
        outI     <= expand(rxData[SAMPLE_W-1 -: NARROW_W], cfgShift);
        outQ     <= expand(rxData[NARROW_W-1:0], cfgShift);
        outShift <= clampShift(cfgShift);
      end else if (st.emitWide) begin
        outI <= rxHold;
        outQ <= rxData;
      end
    end
  end

  assign lowMask = (SAMPLE_W'(1) << (MAX_SHIFT - int'(outShift))) - SAMPLE_W'(1);

  // R8: restored narrow values carry zeros below the window
  a_r8_low_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    st.emitNarrow |=> ((outI & lowMask) == '0) && ((outQ & lowMask) == '0));

  // R5: the first word of a wide pair is the unmodified I component
  a_r5_wide_i_first: assert property (@(posedge clk) disable iff (!rstN)
    st.loadPair && !cfgNarrow |=> busData == $past(inI));
endmodule

// File: rtl/iqBitWindowPacker.sv
module iqBitWindowPacker
  import iqbwPkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int NARROW_W = 8,
  parameter int SHIFT_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgNarrow,
  input  logic [SHIFT_W-1:0]  cfgShift,
  input  logic                inValid,
  output logic                inReady,
  input  logic [SAMPLE_W-1:0] inI,
  input  logic [SAMPLE_W-1:0] inQ,
  output logic                busValid,
  input  logic                busReady,
  output logic [SAMPLE_W-1:0] busData,
  input  logic                rxValid,
  output logic                rxReady,
  input  logic [SAMPLE_W-1:0] rxData,
  output logic                outValid,
  input  logic                outReady,
  output logic [SAMPLE_W-1:0] outI,
  output logic [SAMPLE_W-1:0] outQ
);
  iqbwStrobe_t st;

  iqbwCtrl uCtrl (
    .clk(clk), .rstN(rstN), .cfgNarrow(cfgNarrow),
    .inValid(inValid), .inReady(inReady),
    .busValid(busValid), .busReady(busReady),
    .rxValid(rxValid), .rxReady(rxReady),
    .outValid(outValid), .outReady(outReady),
    .st(st)
  );

  iqbwData #(.SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W), .SHIFT_W(SHIFT_W)) uData (
    .clk(clk), .rstN(rstN), .st(st),
    .cfgNarrow(cfgNarrow), .cfgShift(cfgShift),
    .inI(inI), .inQ(inQ), .rxData(rxData),
    .busData(busData), .outI(outI), .outQ(outQ)
  );

  // R6: a stalled bus word keeps its contents
  a_r6_bus_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busReady |=> $stable(busData));

  // R10: a stalled restored pair keeps its contents
  a_r10_out_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outI) && $stable(outQ));
endmodule

// File: tb/tb_iqBitWindowPacker.sv
module tb_iqBitWindowPacker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgNarrow = 1'b1;
  logic [3:0]  cfgShift = 4'd0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] inI = '0;
  logic [15:0] inQ = '0;
  logic        busValid;
  logic        busReady = 1'b1;
  logic [15:0] busData;
  logic        rxValid = 1'b0;
  logic        rxReady;
  logic [15:0] rxData = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [15:0] outI;
  logic [15:0] outQ;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] busQ[$];
  logic [31:0] pairQ[$];

  always #5 clk = ~clk;

  iqBitWindowPacker dut (
    .clk(clk), .rstN(rstN), .cfgNarrow(cfgNarrow), .cfgShift(cfgShift),
    .inValid(inValid), .inReady(inReady), .inI(inI), .inQ(inQ),
    .busValid(busValid), .busReady(busReady), .busData(busData),
    .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData),
    .outValid(outValid), .outReady(outReady), .outI(outI), .outQ(outQ)
  );

  always @(posedge clk) begin
    if (rstN && busValid && busReady) busQ.push_back(busData);
    if (rstN && outValid && outReady) pairQ.push_back({outI, outQ});
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expectBus(input string tag, input logic [15:0] exp);
    if (busQ.size() == 0) begin
      checks++; errors++;
      $display("FAIL %s: actual=none expected=%h", tag, exp);
    end else check(tag, {16'h0, busQ.pop_front()}, {16'h0, exp});
  endtask

  task automatic expectPair(input string tag, input logic [15:0] ei, input logic [15:0] eq);
    if (pairQ.size() == 0) begin
      checks++; errors++;
      $display("FAIL %s: actual=none expected=%h", tag, {ei, eq});
    end else check(tag, pairQ.pop_front(), {ei, eq});
  endtask

  task automatic sendPair(input logic [15:0] i, input logic [15:0] q);
    @(negedge clk);
    inValid = 1'b1; inI = i; inQ = q;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic sendRx(input logic [15:0] w);
    @(negedge clk);
    rxValid = 1'b1; rxData = w;
    while (!rxReady) @(negedge clk);
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R11 busValid", {31'h0, busValid}, 32'h0);
    check("R11 outValid", {31'h0, outValid}, 32'h0);
    check("R11 inReady", {31'h0, inReady}, 32'h1);
    check("R11 rxReady", {31'h0, rxReady}, 32'h1);
  endtask

  task automatic testNarrowTop();
    cfgNarrow = 1'b1; cfgShift = 4'd0;
    sendPair(16'h1234, 16'hFEDC);
    sendPair(16'h8000, 16'h7FFF);
    settle();
    expectBus("R1 R4 k0 pair a", 16'h12FE);
    expectBus("R1 R4 k0 pair b", 16'h807F);
    check("R4 one word per pair", busQ.size(), 0);
  endtask

  task automatic testNarrowHalf();
    cfgShift = 4'd1;
    sendPair(16'h3F80, 16'hC000);
    sendPair(16'h4000, 16'hBF00);
    settle();
    expectBus("R1 k1 window fits", 16'h7F80);
    expectBus("R2 k1 saturate", 16'h7F80);
  endtask

  task automatic testNarrowLow();
    cfgShift = 4'd8;
    sendPair(16'h0055, 16'hFFAB);
    sendPair(16'h0100, 16'hFF00);
    cfgShift = 4'd12;
    sendPair(16'h0055, 16'hFFAB);
    sendPair(16'h0100, 16'hFE7F);
    settle();
    expectBus("R1 k8 low byte", 16'h55AB);
    expectBus("R2 k8 saturate", 16'h7F80);
    expectBus("R3 k12 as k8", 16'h55AB);
    expectBus("R3 k12 saturate", 16'h7F80);
  endtask

  task automatic testWide();
    cfgNarrow = 1'b0;
    sendPair(16'h1234, 16'hABCD);
    sendPair(16'h8001, 16'h0003);
    settle();
    expectBus("R5 wide I word", 16'h1234);
    expectBus("R5 wide Q word", 16'hABCD);
    expectBus("R5 wide I word 2", 16'h8001);
    expectBus("R5 wide Q word 2", 16'h0003);
  endtask

  task automatic testStallAndSettingChange();
    cfgNarrow = 1'b0; cfgShift = 4'd0;
    busReady = 1'b0;
    sendPair(16'h0F0F, 16'hF0F0);
    cfgNarrow = 1'b1; cfgShift = 4'd3;
    repeat (3) @(negedge clk);
    check("R6 stalled busValid", {31'h0, busValid}, 32'h1);
    check("R6 stalled busData", {16'h0, busData}, 32'h0F0F);
    check("R6 inReady low while held", {31'h0, inReady}, 32'h0);
    busReady = 1'b1;
    settle();
    expectBus("R7 I unchanged by setting", 16'h0F0F);
    expectBus("R7 Q unchanged by setting", 16'hF0F0);
    sendPair(16'h0240, 16'hFE00);
    settle();
    expectBus("R7 next pair uses k3", 16'h12F0);
  endtask

  task automatic testUnpackNarrow();
    cfgNarrow = 1'b1;
    cfgShift = 4'd0; sendRx(16'h807F);
    cfgShift = 4'd8; sendRx(16'hFF01);
    cfgShift = 4'd3; sendRx(16'h12F0);
    cfgShift = 4'd13; sendRx(16'h0180);
    settle();
    expectPair("R8 k0 expand", 16'h8000, 16'h7F00);
    expectPair("R8 k8 expand", 16'hFFFF, 16'h0001);
    expectPair("R8 k3 expand", 16'h0240, 16'hFE00);
    expectPair("R3 k13 expand as k8", 16'h0001, 16'hFF80);
  endtask

  task automatic testUnpackWide();
    cfgNarrow = 1'b0;
    sendRx(16'hABCD);
    settle();
    check("R9 no pair after one word", {31'h0, outValid}, 32'h0);
    sendRx(16'h1234);
    settle();
    expectPair("R9 wide pair", 16'hABCD, 16'h1234);
  endtask

  task automatic testOutStall();
    cfgNarrow = 1'b1; cfgShift = 4'd0;
    outReady = 1'b0;
    sendRx(16'h4020);
    repeat (3) @(negedge clk);
    check("R10 outValid held", {31'h0, outValid}, 32'h1);
    check("R10 outI held", {16'h0, outI}, 32'h4000);
    check("R10 outQ held", {16'h0, outQ}, 32'h2000);
    check("R10 rxReady low", {31'h0, rxReady}, 32'h0);
    outReady = 1'b1;
    settle();
    expectPair("R10 pair delivered once", 16'h4000, 16'h2000);
    check("R10 no duplicate", pairQ.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testNarrowTop();
    testNarrowHalf();
    testNarrowLow();
    testWide();
    testStallAndSettingChange();
    testUnpackNarrow();
    testUnpackWide();
    testOutStall();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule